// File: doc/BRIEF.md
# Shadow Stack Push and Pop-Check Unit

This unit carries out shadow-stack operations for a processor pipeline. It holds the shadow stack pointer. It takes one decoded request at a time, either a push of a return address or a pop-check that compares a saved address, and runs the memory access through a simple valid/ready request port and a response port. A pop-check loads the saved word and compares it with the register value it was given. When the two differ, the unit raises a software-check fault and leaves the pointer as it was.

The pipeline resolves the privilege-based enable and presents it on `ss_en`. When the enable is low, every request retires as a no-op. The request can be a full-width push or pop-check, or a compressed may-be-operation whose destination field selects the action. The compressed push always takes the return-address register value. The compressed pop-check always compares against the alternate link register value. A CSR-style write port loads the pointer while no operation is in flight. Memory errors are reported on their own access-fault output.

Top module: `sstk_unit`

## Requirements
- R1: After a synchronous active-low reset, `ssp_o` is 0, `req_ready` is 1, and `mem_req_valid`, `done_o`, `sw_fault_o` and `acc_fault_o` are 0.
- R2: An enabled push (`req_kind`=0) issues a write (`mem_req_we`=1) at address `ssp_o`-XLEN/8 with write data `rs_val`. One cycle after an error-free response, `done_o` pulses and `ssp_o` equals that address.
- R3: An enabled pop-check (`req_kind`=1) issues a read at address `ssp_o`. If the read data equals the operand, then one cycle after the response `done_o` pulses and `ssp_o` has grown by XLEN/8.
- R4: If the pop-check read data differs from the operand, then one cycle after the response `sw_fault_o` pulses and `sw_fault_tval` equals FAULT_TVAL (default 3). `ssp_o` is unchanged and `done_o` stays low.
- R5: `mem_req_size` is 2 (4 bytes) when XLEN is 32 and 3 (8 bytes) when XLEN is 64.
- R6: With `ss_en`=0, any accepted request makes no memory request, leaves `ssp_o` unchanged, raises no fault, and pulses `done_o` one cycle after acceptance.
- R7: A compressed request (`req_kind`=2) with `req_crd`=1 pushes `ra_val`, and one with `req_crd`=5 pop-checks against `t0_val`. Any other `req_crd`, `req_kind`=3, or HAS_SS=0 gives a no-op that pulses `done_o` one cycle after acceptance.
- R8: `req_ready` is low while an operation is in flight. `mem_req_valid` and its address, data and size stay stable until `mem_req_ready` is seen. A request held high during an operation is not taken again.
- R9: A response with `mem_rsp_err`=1 pulses `acc_fault_o` one cycle later. `ssp_o` is unchanged and neither `done_o` nor `sw_fault_o` pulses.
- R10: `ssp_wr_en` with no operation in flight loads `ssp_wr_data` into `ssp_o` on the next edge. `req_ready` is low in that cycle. A write made while an operation is in flight is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ss_en | input | 1 | Resolved shadow-stack enable |
| req_valid | input | 1 | Operation request valid |
| req_ready | output | 1 | Unit can accept a request |
| req_kind | input | 2 | 0 push, 1 pop-check, 2 compressed may-be-op, 3 plain no-op |
| req_crd | input | 5 | Destination field of a compressed may-be-op |
| rs_val | input | XLEN | Operand for the full-width forms |
| ra_val | input | XLEN | Return-address register value (compressed push) |
| t0_val | input | XLEN | Alternate link register value (compressed pop-check) |
| ssp_wr_en | input | 1 | Pointer write strobe |
| ssp_wr_data | input | XLEN | Pointer write value |
| ssp_o | output | XLEN | Current shadow stack pointer |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_we | output | 1 | 1 store, 0 load |
| mem_req_addr | output | XLEN | Byte address |
| mem_req_wdata | output | XLEN | Store data |
| mem_req_size | output | 2 | log2 of the access bytes |
| mem_rsp_valid | input | 1 | Memory response valid |
| mem_rsp_rdata | input | XLEN | Load data |
| mem_rsp_err | input | 1 | Memory access error |
| done_o | output | 1 | Operation retired without fault (pulse) |
| sw_fault_o | output | 1 | Software-check fault (pulse) |
| sw_fault_tval | output | XLEN | Fault trap value, valid with sw_fault_o |
| acc_fault_o | output | 1 | Memory access fault (pulse) |

## Verification
A corrupted pointer shows up at the ports at once: `ssp_o` is compared every cycle, and the next push or pop-check presents a wrong `mem_req_addr` in the first cycle its request is valid. A sequencer stuck in or out of the wait state appears as a wrong `req_ready` or a missing or extra `done_o` pulse within one cycle of the response. A wrong compare path shows as `sw_fault_o` taking the place of `done_o` in the cycle after the load returns.

// File: rtl/sstk_pkg.sv
// Shared types for the shadow-stack unit.
// Assumes: the request kind encoding is fixed by the pipeline decoder.
package sstk_pkg;

    typedef enum logic [1:0] {
        K_PUSH   = 2'd0,
        K_POPCHK = 2'd1,
        K_CMOP   = 2'd2,
        K_NONE   = 2'd3
    } sstk_kind_e;

    typedef enum logic [1:0] {
        ACT_NOP  = 2'd0,
        ACT_PUSH = 2'd1,
        ACT_POP  = 2'd2
    } sstk_act_e;

    typedef enum logic {
        ST_IDLE     = 1'b0,
        ST_MEM_WAIT = 1'b1
    } sstk_state_e;

    localparam logic [4:0] CMOP_PUSH_RD = 5'd1;
    localparam logic [4:0] CMOP_POP_RD  = 5'd5;

    // log2 of the access bytes for a given register width
    function automatic logic [1:0] size_code(int unsigned w);
        return (w == 64) ? 2'd3 : 2'd2;
    endfunction

endpackage

// File: rtl/sstk_decode.sv
// Maps a request to an action and an operand.
// Assumes: HAS_SS tells whether the shadow-stack extension exists; when it
// does not, every compressed may-be-op is an ordinary no-op.
module sstk_decode
    import sstk_pkg::*;
#(
    parameter int XLEN   = 64,
    parameter bit HAS_SS = 1'b1
) (
    input  logic            ss_en,
    input  logic [1:0]      kind,
    input  logic [4:0]      crd,
    input  logic [XLEN-1:0] rs_val,
    input  logic [XLEN-1:0] ra_val,
    input  logic [XLEN-1:0] t0_val,
    output sstk_act_e       act,
    output logic [XLEN-1:0] operand
);

    // select the action and source register value
    always_comb begin
        act     = ACT_NOP;
        operand = rs_val;
        unique case (sstk_kind_e'(kind))
            K_PUSH:   act = ACT_PUSH;
            K_POPCHK: act = ACT_POP;
            K_CMOP: begin
                if (HAS_SS && crd == CMOP_PUSH_RD) begin
                    act     = ACT_PUSH;
                    operand = ra_val;
                end else if (HAS_SS && crd == CMOP_POP_RD) begin
                    act     = ACT_POP;
                    operand = t0_val;
                end
            end
            default:  act = ACT_NOP;
        endcase
        if (!ss_en) begin
            act = ACT_NOP;
        end
    end

endmodule

// File: rtl/sstk_ptr.sv
// Shadow stack pointer register.
// Assumes: the sequencer never raises the write strobe and the update strobe
// together.
module sstk_ptr #(
    parameter int XLEN = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [XLEN-1:0] wr_data,
    input  logic            upd_en,
    input  logic [XLEN-1:0] upd_val,
    output logic [XLEN-1:0] ssp
);

    // hold the pointer; an operation result or a software write loads it
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ssp <= '0;
        end else if (upd_en) begin
            ssp <= upd_val;
        end else if (wr_en) begin
            ssp <= wr_data;
        end
    end

    AST_PTR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && upd_en)); // R10

endmodule

// File: rtl/sstk_seq.sv
// Two-state sequencer: accepts a request in IDLE, runs one memory access in
// MEM_WAIT, compares the load for pop-check, and reports the outcome one
// cycle after the response.
// Assumes: a response is only taken after the request handshake, and one
// memory access is outstanding at most.
module sstk_seq
    import sstk_pkg::*;
#(
    parameter int XLEN       = 64,
    parameter int FAULT_TVAL = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    output logic            req_ready,
    input  sstk_act_e       act,
    input  logic [XLEN-1:0] operand,
    input  logic [XLEN-1:0] ssp,
    input  logic            ssp_wr_en,
    output logic            ptr_wr_en,
    output logic            ptr_upd_en,
    output logic [XLEN-1:0] ptr_upd_val,
    output logic            mem_req_valid,
    input  logic            mem_req_ready,
    output logic            mem_req_we,
    output logic [XLEN-1:0] mem_req_addr,
    output logic [XLEN-1:0] mem_req_wdata,
    output logic [1:0]      mem_req_size,
    input  logic            mem_rsp_valid,
    input  logic [XLEN-1:0] mem_rsp_rdata,
    input  logic            mem_rsp_err,
    output logic            done_o,
    output logic            sw_fault_o,
    output logic [XLEN-1:0] sw_fault_tval,
    output logic            acc_fault_o
);

    localparam logic [XLEN-1:0] STEP = XLEN'(XLEN / 8);
    localparam logic [XLEN-1:0] TVAL = XLEN'(FAULT_TVAL);
    localparam logic [1:0]      SIZE = size_code(XLEN);

    sstk_state_e     state_q;
    logic            issued_q;
    logic            push_q;
    logic [XLEN-1:0] addr_q;
    logic [XLEN-1:0] data_q;
    logic            done_q;
    logic            swf_q;
    logic            accf_q;

    logic            accept;
    logic            rsp_take;
    logic            match;

    // handshake and response qualification
    always_comb begin
        req_ready = (state_q == ST_IDLE) && !ssp_wr_en;
        accept    = req_ready && req_valid;
        rsp_take  = (state_q == ST_MEM_WAIT) && issued_q && mem_rsp_valid;
        match     = (mem_rsp_rdata == data_q);
        ptr_wr_en = (state_q == ST_IDLE) && ssp_wr_en;
    end

    // pointer result of a successful access
    always_comb begin
        ptr_upd_en  = rsp_take && !mem_rsp_err && (push_q || match);
        ptr_upd_val = push_q ? addr_q : addr_q + STEP;
    end

    // memory request port
    always_comb begin
        mem_req_valid = (state_q == ST_MEM_WAIT) && !issued_q;
        mem_req_we    = push_q;
        mem_req_addr  = addr_q;
        mem_req_wdata = data_q;
        mem_req_size  = SIZE;
    end

    // sequencer state, latched access and outcome pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            issued_q <= 1'b0;
            push_q   <= 1'b0;
            addr_q   <= '0;
            data_q   <= '0;
            done_q   <= 1'b0;
            swf_q    <= 1'b0;
            accf_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            swf_q  <= 1'b0;
            accf_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        if (act == ACT_NOP) begin
                            done_q <= 1'b1;
                        end else begin
                            state_q  <= ST_MEM_WAIT;
                            issued_q <= 1'b0;
                            push_q   <= (act == ACT_PUSH);
                            addr_q   <= (act == ACT_PUSH) ? ssp - STEP : ssp;
                            data_q   <= operand;
                        end
                    end
                end
                ST_MEM_WAIT: begin
                    if (!issued_q) begin
                        if (mem_req_ready) begin
                            issued_q <= 1'b1;
                        end
                    end else if (mem_rsp_valid) begin
                        state_q <= ST_IDLE;
                        if (mem_rsp_err) begin
                            accf_q <= 1'b1;
                        end else if (push_q || match) begin
                            done_q <= 1'b1;
                        end else begin
                            swf_q <= 1'b1;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // outcome outputs
    always_comb begin
        done_o        = done_q;
        sw_fault_o    = swf_q;
        acc_fault_o   = accf_q;
        sw_fault_tval = swf_q ? TVAL : '0;
    end

    AST_MEMREQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_wdata)); // R8
    AST_NO_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> !req_ready); // R8
    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done_o, sw_fault_o, acc_fault_o})); // R4
    AST_NOP_NO_MEM: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready && act == ACT_NOP |=> !mem_req_valid && done_o); // R6

endmodule

// File: rtl/sstk_unit.sv
// Shadow-stack push and pop-check unit: decode, sequencer and pointer.
// Assumes: the enable input already folds in privilege and virtualisation;
// address translation and trap delivery live outside.
module sstk_unit #(
    parameter int XLEN       = 64,
    parameter bit HAS_SS     = 1'b1,
    parameter int FAULT_TVAL = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ss_en,
    input  logic            req_valid,
    output logic            req_ready,
    input  logic [1:0]      req_kind,
    input  logic [4:0]      req_crd,
    input  logic [XLEN-1:0] rs_val,
    input  logic [XLEN-1:0] ra_val,
    input  logic [XLEN-1:0] t0_val,
    input  logic            ssp_wr_en,
    input  logic [XLEN-1:0] ssp_wr_data,
    output logic [XLEN-1:0] ssp_o,
    output logic            mem_req_valid,
    input  logic            mem_req_ready,
    output logic            mem_req_we,
    output logic [XLEN-1:0] mem_req_addr,
    output logic [XLEN-1:0] mem_req_wdata,
    output logic [1:0]      mem_req_size,
    input  logic            mem_rsp_valid,
    input  logic [XLEN-1:0] mem_rsp_rdata,
    input  logic            mem_rsp_err,
    output logic            done_o,
    output logic            sw_fault_o,
    output logic [XLEN-1:0] sw_fault_tval,
    output logic            acc_fault_o
);
    import sstk_pkg::*;

    localparam logic [XLEN-1:0] STEP = XLEN'(XLEN / 8);

    sstk_act_e       act;
    logic [XLEN-1:0] operand;
    logic            ptr_wr_en;
    logic            ptr_upd_en;
    logic [XLEN-1:0] ptr_upd_val;

    sstk_decode #(.XLEN(XLEN), .HAS_SS(HAS_SS)) u_decode (
        .ss_en   (ss_en),
        .kind    (req_kind),
        .crd     (req_crd),
        .rs_val  (rs_val),
        .ra_val  (ra_val),
        .t0_val  (t0_val),
        .act     (act),
        .operand (operand)
    );

    sstk_seq #(.XLEN(XLEN), .FAULT_TVAL(FAULT_TVAL)) u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .req_ready     (req_ready),
        .act           (act),
        .operand       (operand),
        .ssp           (ssp_o),
        .ssp_wr_en     (ssp_wr_en),
        .ptr_wr_en     (ptr_wr_en),
        .ptr_upd_en    (ptr_upd_en),
        .ptr_upd_val   (ptr_upd_val),
        .mem_req_valid (mem_req_valid),
        .mem_req_ready (mem_req_ready),
        .mem_req_we    (mem_req_we),
        .mem_req_addr  (mem_req_addr),
        .mem_req_wdata (mem_req_wdata),
        .mem_req_size  (mem_req_size),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_rdata (mem_rsp_rdata),
        .mem_rsp_err   (mem_rsp_err),
        .done_o        (done_o),
        .sw_fault_o    (sw_fault_o),
        .sw_fault_tval (sw_fault_tval),
        .acc_fault_o   (acc_fault_o)
    );

    sstk_ptr #(.XLEN(XLEN)) u_ptr (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (ptr_wr_en),
        .wr_data (ssp_wr_data),
        .upd_en  (ptr_upd_en),
        .upd_val (ptr_upd_val),
        .ssp     (ssp_o)
    );

    AST_FAULT_KEEPS_SSP: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_fault_o || acc_fault_o) |-> $stable(ssp_o)); // R4 R9
    AST_PUSH_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && mem_req_we |-> mem_req_addr == ssp_o - STEP); // R2
    AST_POP_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_we |-> mem_req_addr == ssp_o); // R3

endmodule

// File: tb/sstk_unit_bench.sv
module sstk_unit_bench;

    localparam int CLK_PERIOD = 10;
    localparam int XLEN = 64;
    localparam logic [63:0] STEP = 64'd8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ss_en = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [1:0]  req_kind = 2'd0;
    logic [4:0]  req_crd = 5'd0;
    logic [63:0] rs_val = '0, ra_val = '0, t0_val = '0;
    logic        ssp_wr_en = 1'b0;
    logic [63:0] ssp_wr_data = '0;
    logic [63:0] ssp_o;
    logic        mem_req_valid, mem_req_we;
    logic        mem_req_ready = 1'b0;
    logic [63:0] mem_req_addr, mem_req_wdata;
    logic [1:0]  mem_req_size;
    logic        mem_rsp_valid = 1'b0;
    logic [63:0] mem_rsp_rdata = '0;
    logic        mem_rsp_err = 1'b0;
    logic        done_o, sw_fault_o, acc_fault_o;
    logic [63:0] sw_fault_tval;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    string cur_req = "R1";
    bit cmp_on = 1'b0;

    // reference model state
    bit          m_busy, m_issued, m_push, m_acc, m_done, m_swf, m_accf;
    logic [63:0] m_ssp, m_addr, m_val;

    // memory responder knobs
    int rdy_lat = 0, rsp_lat = 0, rdy_cnt = 0, rsp_cnt = 0;
    bit give_err = 1'b0;
    logic [63:0] bmem [logic [63:0]];

    sstk_unit #(.XLEN(XLEN)) u_sstk_unit (
        .clk(clk), .rst_n(rst_n), .ss_en(ss_en),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_kind(req_kind), .req_crd(req_crd),
        .rs_val(rs_val), .ra_val(ra_val), .t0_val(t0_val),
        .ssp_wr_en(ssp_wr_en), .ssp_wr_data(ssp_wr_data), .ssp_o(ssp_o),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_we(mem_req_we), .mem_req_addr(mem_req_addr),
        .mem_req_wdata(mem_req_wdata), .mem_req_size(mem_req_size),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_rdata(mem_rsp_rdata),
        .mem_rsp_err(mem_rsp_err),
        .done_o(done_o), .sw_fault_o(sw_fault_o),
        .sw_fault_tval(sw_fault_tval), .acc_fault_o(acc_fault_o)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic chk(string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h at cycle %0d", cur_req, what, act, exp, cycles);
        end
    endtask

    // behavioural model, advanced on every rising edge
    always @(posedge clk) begin
        int a;
        logic [63:0] v;
        cycles++;
        m_acc = 0; m_done = 0; m_swf = 0; m_accf = 0;
        if (!rst_n) begin
            m_busy = 0; m_issued = 0; m_push = 0; m_ssp = '0;
        end else if (!m_busy) begin
            if (ssp_wr_en) begin
                m_ssp = ssp_wr_data;
            end else if (req_valid) begin
                m_acc = 1;
                a = 0; v = rs_val;
                if (req_kind == 2'd0) a = 1;
                else if (req_kind == 2'd1) a = 2;
                else if (req_kind == 2'd2 && req_crd == 5'd1) begin a = 1; v = ra_val; end
                else if (req_kind == 2'd2 && req_crd == 5'd5) begin a = 2; v = t0_val; end
                if (!ss_en) a = 0;
                if (a == 0) m_done = 1;
                else begin
                    m_busy = 1; m_issued = 0; m_push = (a == 1);
                    m_addr = m_push ? m_ssp - STEP : m_ssp;
                    m_val = v;
                end
            end
        end else if (!m_issued) begin
            if (mem_req_ready) m_issued = 1;
        end else if (mem_rsp_valid) begin
            m_busy = 0;
            if (mem_rsp_err) m_accf = 1;
            else if (m_push) begin m_ssp = m_addr; m_done = 1; end
            else if (mem_rsp_rdata == m_val) begin m_ssp = m_ssp + STEP; m_done = 1; end
            else m_swf = 1;
        end
    end

    // memory responder, driven on falling edges
    always @(negedge clk) begin
        if (!m_busy) begin
            mem_req_ready = 0; mem_rsp_valid = 0; mem_rsp_err = 0;
            rdy_cnt = rdy_lat; rsp_cnt = rsp_lat;
        end else if (!m_issued) begin
            if (rdy_cnt == 0) mem_req_ready = 1;
            else begin mem_req_ready = 0; rdy_cnt--; end
        end else begin
            mem_req_ready = 0;
            if (rsp_cnt == 0) begin
                mem_rsp_valid = 1;
                mem_rsp_err = give_err;
                if (m_push) begin
                    if (!give_err) bmem[m_addr] = m_val;
                    mem_rsp_rdata = '0;
                end else begin
                    mem_rsp_rdata = bmem.exists(m_addr) ? bmem[m_addr] : 64'h0;
                end
            end else begin
                rsp_cnt--;
            end
        end
    end

    // compare outputs with the model in the quiet part of each cycle
    always @(negedge clk) begin
        #(CLK_PERIOD / 4);
        if (cmp_on) begin
            chk("ssp_o", ssp_o, m_ssp);
            chk("req_ready", 64'(req_ready), 64'(!m_busy && !ssp_wr_en));
            chk("mem_req_valid", 64'(mem_req_valid), 64'(m_busy && !m_issued));
            chk("done_o", 64'(done_o), 64'(m_done));
            chk("sw_fault_o", 64'(sw_fault_o), 64'(m_swf));
            chk("acc_fault_o", 64'(acc_fault_o), 64'(m_accf));
            if (m_swf) chk("sw_fault_tval", sw_fault_tval, 64'd3);
            if (m_busy && !m_issued) begin
                chk("mem_req_addr", mem_req_addr, m_addr);
                chk("mem_req_we", 64'(mem_req_we), 64'(m_push));
                chk("mem_req_size", 64'(mem_req_size), 64'd3);
                if (m_push) chk("mem_req_wdata", mem_req_wdata, m_val);
            end
        end
    end

    // watchdog
    initial begin
        #(CLK_PERIOD * 100000);
        failures++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    task automatic wait_idle();
        do begin @(posedge clk); #1; end while (m_busy);
        repeat (2) @(posedge clk);
    endtask

    task automatic do_op(string tag, logic [1:0] kind, logic [4:0] crd, logic [63:0] val, bit hold);
        @(negedge clk);
        cur_req = tag;
        req_kind = kind; req_crd = crd; rs_val = val;
        req_valid = 1;
        do begin @(posedge clk); #1; end while (!m_acc);
        if (hold) begin
            while (m_busy) @(negedge clk);
        end
        @(negedge clk);
        req_valid = 0;
        wait_idle();
    endtask

    initial begin
        repeat (3) @(posedge clk);
        cmp_on = 1;
        cur_req = "R1";
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        repeat (2) @(posedge clk);

        // R10: pointer load while idle
        @(negedge clk);
        cur_req = "R10";
        ssp_wr_en = 1; ssp_wr_data = 64'h1000;
        @(negedge clk);
        ssp_wr_en = 0;
        repeat (2) @(posedge clk);

        // R2: pushes with zero and non-zero latencies; R5 size checked on each request
        do_op("R2", 2'd0, 5'd0, 64'hAAAA_0001, 0);
        rdy_lat = 2; rsp_lat = 3;
        do_op("R5", 2'd0, 5'd0, 64'hBBBB_0002, 0);
        // R8: request held high through the operation
        do_op("R8", 2'd0, 5'd0, 64'hCCCC_0003, 1);
        rdy_lat = 0; rsp_lat = 0;

        // R3: matching pop-check
        do_op("R3", 2'd1, 5'd0, 64'hCCCC_0003, 0);
        // R4: mismatching pop-check, pointer unchanged
        do_op("R4", 2'd1, 5'd0, 64'h1234_5678, 0);
        do_op("R3", 2'd1, 5'd0, 64'hBBBB_0002, 0);

        // R6: disabled operations are no-ops
        ss_en = 0;
        do_op("R6", 2'd0, 5'd0, 64'h9999, 0);
        do_op("R6", 2'd1, 5'd0, 64'h9999, 0);
        do_op("R6", 2'd2, 5'd1, 64'h9999, 0);
        ss_en = 1;

        // R7: compressed forms use the fixed link registers
        ra_val = 64'hDEAD_BEEF_0000_0007; t0_val = 64'h5555;
        do_op("R7", 2'd2, 5'd1, 64'h0, 0);
        t0_val = 64'hDEAD_BEEF_0000_0007;
        do_op("R7", 2'd2, 5'd5, 64'h0, 0);
        do_op("R7", 2'd2, 5'd3, 64'h0, 0);
        do_op("R7", 2'd3, 5'd0, 64'h0, 0);
        t0_val = 64'h1;
        ra_val = 64'h2;
        do_op("R7", 2'd2, 5'd5, 64'hAAAA_0001, 0);

        // R9: access errors on push and pop-check
        give_err = 1;
        do_op("R9", 2'd0, 5'd0, 64'h7777, 0);
        do_op("R9", 2'd1, 5'd0, 64'hAAAA_0001, 0);
        give_err = 0;

        // R10: write during an operation is dropped
        rsp_lat = 4;
        @(negedge clk);
        cur_req = "R10";
        req_kind = 2'd0; rs_val = 64'h4242; req_valid = 1;
        do begin @(posedge clk); #1; end while (!m_acc);
        @(negedge clk);
        req_valid = 0;
        ssp_wr_en = 1; ssp_wr_data = 64'hFFFF_0000;
        @(negedge clk);
        ssp_wr_en = 0;
        wait_idle();
        rsp_lat = 0;

        // R10: write and request together, write wins the cycle
        @(negedge clk);
        ssp_wr_en = 1; ssp_wr_data = 64'h2000;
        req_kind = 2'd0; rs_val = 64'h5151; req_valid = 1;
        @(negedge clk);
        ssp_wr_en = 0;
        do begin @(posedge clk); #1; end while (!m_acc);
        @(negedge clk);
        req_valid = 0;
        wait_idle();
        do_op("R3", 2'd1, 5'd0, 64'h5151, 0);

        repeat (3) @(posedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule